// File: doc/BRIEF.md
# Serial Flash Sequential Read Engine

This block is the device-side decoder for the plain read command of a serial flash. When chip select goes low it collects a one-byte opcode and a 24-bit start address from the serial input. It samples each bit on a rising edge of the serial clock. It then sends bytes from the memory array on the serial output, changing the line on each falling edge, for as long as the host keeps clocking. The byte address advances by one after each byte. Past the last location it returns to zero, so a single command can sweep the whole array any number of times.

The serial pins are sampled by the system clock. The block detects serial-clock edges from those samples. Bytes are fetched through a synchronous byte-wide read port whose data is valid one system cycle after the request. The block requests each byte one byte ahead of the shifter. A busy input from the program and erase logic is checked when the opcode completes. A read that arrives during a running cycle is refused: it makes no memory request and leaves the output disabled until chip select rises. Raising chip select at any bit ends the command.

Top module: `spi_seq_read`

## Requirements
- R1: A command is the opcode 0x03 followed by a 24-bit address, all sent most significant bit first and sampled on rising serial-clock edges while chip select is low. The low log2(MEM_DEPTH) address bits select the start byte, which may be any location. Higher address bits are ignored. MEM_DEPTH is a power of two of at least 4.
- R2: Read data leaves most significant bit first and changes only after falling serial-clock edges. The first byte's top bit is presented after the first falling edge that follows the 32nd rising edge. The output enable is high from that point until chip select rises.
- R3: Each following byte comes from the previous address plus one. Output continues for as many bytes as the host clocks.
- R4: The byte that follows address MEM_DEPTH-1 is read from address 0.
- R5: Chip select going high ends the command at any bit, including mid-byte. The output enable falls within two system cycles, and the next command is decoded from its first bit.
- R6: If busy is high when the eighth opcode bit is sampled, the command is rejected. It issues no memory read, and the output enable stays low until chip select rises.
- R7: Any opcode other than 0x03 is ignored. It issues no memory read, and the output enable stays low.
- R8: The output enable is low after reset and whenever chip select is high.
- R9: Each memory read is a one-cycle request pulse, and its data is taken one cycle later. A command that delivers N complete bytes issues exactly N+1 reads: the first at the end of the address, then one at the start of each byte for the next address. The serial clock must stay at each level for at least three system cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| spiCsN | input | 1 | Serial chip select, active low |
| spiSclk | input | 1 | Serial clock from the host |
| spiMosi | input | 1 | Serial data from the host |
| spiMiso | output | 1 | Serial read data to the host |
| spiMisoOe | output | 1 | Output enable for spiMiso (low means high impedance) |
| busy | input | 1 | High while a program, erase or status-write cycle runs |
| memRdEn | output | 1 | One-cycle memory read request |
| memAddr | output | log2(MEM_DEPTH) | Memory byte address of the request |
| memData | input | 8 | Memory data, valid the cycle after memRdEn |

## Verification
The serial inputs pass one register stage, and edge detection needs one more, so a falling serial-clock edge updates spiMiso about two system cycles after the pin moves. Chip select rising clears the output enable one cycle after the pin. Memory data is due one cycle after each request and is parked a cycle later. The bench holds each serial-clock level for four system cycles and reads spiMiso and the enable at the end of the low phase, just before the next rising edge. Enable-off checks are made three cycles after chip select rises, so every result is sampled after its latest due cycle and before the next stimulus.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

  // Strobes from the control to the datapath, one cycle wide each.
  typedef struct packed {
    logic shiftIn;    // take one command/address bit
    logic loadStart;  // last address bit: latch start address, request byte
    logic loadByte;   // first falling edge of a byte: load shifter, prefetch next
    logic shiftOut;   // other falling edges of a byte: advance shifter
  } rdStrobes_t;

  typedef enum logic [1:0] {
    ST_OPCODE = 2'd0,
    ST_ADDR   = 2'd1,
    ST_STREAM = 2'd2,
    ST_REJECT = 2'd3
  } rdState_t;

endpackage

// File: rtl/spi_rd_ctrl.sv
module spi_rd_ctrl
  import spi_rd_pkg::*;
#(
  parameter logic [7:0] READ_OP = 8'h03
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiCsN,
  input  logic       spiSclk,
  input  logic       spiMosi,
  input  logic       busy,
  input  logic [7:0] opcodeNow,
  output rdStrobes_t strobes,
  output logic       bitIn,
  output logic       misoOe
);

  localparam logic [4:0] OP_LAST   = 5'd7;
  localparam logic [4:0] ADDR_LAST = 5'd23;

  logic     csnQ, sclkQ, sclkD, mosiQ, busyQ;
  logic     rise, fall;
  rdState_t state;
  logic [4:0] bitCnt;
  logic [2:0] outCnt;
  logic     streaming;

  // Input sampling and serial-clock edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      csnQ  <= 1'b1;
      sclkQ <= 1'b0;
      sclkD <= 1'b0;
      mosiQ <= 1'b0;
      busyQ <= 1'b0;
    end else begin
      csnQ  <= spiCsN;
      sclkQ <= spiSclk;
      sclkD <= sclkQ;
      mosiQ <= spiMosi;
      busyQ <= busy;
    end
  end

  assign rise  = sclkQ & ~sclkD & ~csnQ;
  assign fall  = ~sclkQ & sclkD & ~csnQ;
  assign bitIn = mosiQ;

  always_comb begin
    strobes.shiftIn   = rise && (state == ST_OPCODE || state == ST_ADDR);
    strobes.loadStart = rise && (state == ST_ADDR) && (bitCnt == ADDR_LAST);
    strobes.loadByte  = fall && (state == ST_STREAM) && (outCnt == 3'd0);
    strobes.shiftOut  = fall && (state == ST_STREAM) && (outCnt != 3'd0);
  end

  always_ff @(posedge clk) begin
    if (!rstN || csnQ) begin
      state     <= ST_OPCODE;
      bitCnt    <= '0;
      outCnt    <= '0;
      streaming <= 1'b0;
    end else begin
      if (rise) begin
        unique case (state)
          ST_OPCODE: begin
            if (bitCnt == OP_LAST) begin
              bitCnt <= '0;
              state  <= (opcodeNow == READ_OP && !busyQ) ? ST_ADDR : ST_REJECT;
            end else begin
              bitCnt <= bitCnt + 5'd1;
            end
          end
          ST_ADDR: begin
            if (bitCnt == ADDR_LAST) begin
              bitCnt <= '0;
              state  <= ST_STREAM;
            end else begin
              bitCnt <= bitCnt + 5'd1;
            end
          end
          default: ;
        endcase
      end
      if (strobes.loadByte || strobes.shiftOut) outCnt <= outCnt + 3'd1;
      if (strobes.loadByte) streaming <= 1'b1;
    end
  end

  assign misoOe = streaming & ~csnQ;

  // R8
  cs_high_oe_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    csnQ |=> !misoOe);

  // R6
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rise && state == ST_OPCODE && bitCnt == OP_LAST && busyQ) |=> state == ST_REJECT);

  // R7
  bad_opcode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rise && state == ST_OPCODE && bitCnt == OP_LAST && opcodeNow != READ_OP)
      |=> state == ST_REJECT);

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadStart, strobes.loadByte, strobes.shiftOut}));

endmodule

// File: rtl/spi_rd_dp.sv
module spi_rd_dp
  import spi_rd_pkg::*;
#(
  parameter int MEM_DEPTH = 4096,
  parameter int ADDR_W    = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobes_t        strobes,
  input  logic              bitIn,
  input  logic [7:0]        memData,
  output logic [7:0]        opcodeNow,
  output logic              spiMiso,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr
);

  // The input shifter keeps only the bits the opcode and array index need.
  localparam int SH_W = (ADDR_W > 8) ? ADDR_W - 1 : 7;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(MEM_DEPTH - 1);

  logic [SH_W-1:0]   inShift;
  logic [ADDR_W-1:0] startAddr, fetchAddr, nextAddr;
  logic              rdReq, rdPend;
  logic [7:0]        nextByte, outShift;

  assign opcodeNow = {inShift[6:0], bitIn};
  assign startAddr = {inShift[ADDR_W-2:0], bitIn};
  assign nextAddr  = (fetchAddr == LAST_ADDR) ? '0 : fetchAddr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inShift   <= '0;
      fetchAddr <= '0;
      rdReq     <= 1'b0;
      rdPend    <= 1'b0;
      nextByte  <= '0;
      outShift  <= '0;
    end else begin
      if (strobes.shiftIn) inShift <= {inShift[SH_W-2:0], bitIn};
      if (strobes.loadStart)     fetchAddr <= startAddr;
      else if (strobes.loadByte) fetchAddr <= nextAddr;
      rdReq  <= strobes.loadStart | strobes.loadByte;
      rdPend <= rdReq;
      if (rdPend) nextByte <= memData;
      if (strobes.loadByte)      outShift <= nextByte;
      else if (strobes.shiftOut) outShift <= {outShift[6:0], 1'b0};
    end
  end

  assign memRdEn = rdReq;
  assign memAddr = fetchAddr;
  assign spiMiso = outShift[7];

  // R9
  single_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  // R4
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadByte && fetchAddr == LAST_ADDR) |=> fetchAddr == '0);

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadByte && fetchAddr != LAST_ADDR) |=> fetchAddr == $past(fetchAddr) + 1'b1);

  // R2
  msb_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadByte |=> spiMiso == $past(nextByte[7]));

endmodule

// File: rtl/spi_seq_read.sv
module spi_seq_read
  import spi_rd_pkg::*;
#(
  parameter int         MEM_DEPTH = 4096,
  parameter logic [7:0] READ_OP   = 8'h03,
  parameter int         ADDR_W    = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiCsN,
  input  logic              spiSclk,
  input  logic              spiMosi,
  output logic              spiMiso,
  output logic              spiMisoOe,
  input  logic              busy,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memData
);

  rdStrobes_t strobes;
  logic       bitIn;
  logic [7:0] opcodeNow;

  spi_rd_ctrl #(.READ_OP(READ_OP)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .spiCsN   (spiCsN),
    .spiSclk  (spiSclk),
    .spiMosi  (spiMosi),
    .busy     (busy),
    .opcodeNow(opcodeNow),
    .strobes  (strobes),
    .bitIn    (bitIn),
    .misoOe   (spiMisoOe)
  );

  spi_rd_dp #(.MEM_DEPTH(MEM_DEPTH), .ADDR_W(ADDR_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .bitIn    (bitIn),
    .memData  (memData),
    .opcodeNow(opcodeNow),
    .spiMiso  (spiMiso),
    .memRdEn  (memRdEn),
    .memAddr  (memAddr)
  );

endmodule

// File: tb/spi_seq_read_tb_top.sv
`timescale 1ns/1ps
module spi_seq_read_tb_top;

  localparam int DEPTH = 64;
  localparam int AW    = 6;
  localparam int HP    = 4;   // system cycles per serial-clock level

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiCsN = 1'b1, spiSclk = 1'b0, spiMosi = 1'b0, busy = 1'b0;
  logic spiMiso, spiMisoOe, memRdEn;
  logic [AW-1:0] memAddr;
  logic [7:0] memData = 8'h00;
  int rdCount = 0;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  spi_seq_read #(.MEM_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSclk(spiSclk), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .spiMisoOe(spiMisoOe), .busy(busy),
    .memRdEn(memRdEn), .memAddr(memAddr), .memData(memData)
  );

  function automatic logic [7:0] memByte(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  always_ff @(posedge clk) begin
    if (memRdEn) begin
      memData <= memByte(int'(memAddr));
      rdCount <= rdCount + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one command. cutBit >= 0 raises chip select before that data bit.
  task automatic runCmd(input logic [7:0] op, input logic [23:0] addr, input int nBytes,
                        input int cutBit, input bit expectOut, input string req);
    logic [31:0] word;
    logic [7:0]  got;
    int startRd, bytesDone;
    word = {op, addr};
    startRd = rdCount;
    bytesDone = 0;
    got = '0;
    spiCsN = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 31; i >= 0; i--) begin
      spiMosi = word[i];
      repeat (HP) @(negedge clk);
      spiSclk = 1'b1;
      repeat (HP) @(negedge clk);
      spiSclk = 1'b0;
    end
    for (int k = 0; k < nBytes * 8; k++) begin
      if (k == cutBit) break;
      repeat (HP) @(negedge clk);
      got[7 - (k % 8)] = spiMiso;
      if (expectOut) begin
        if (k % 8 == 0) chk(spiMisoOe == 1'b1, "R2 oe", int'(spiMisoOe), 1);
      end else begin
        chk(spiMisoOe == 1'b0, req, int'(spiMisoOe), 0);
      end
      if (k % 8 == 7) begin
        if (expectOut)
          chk(got == memByte((int'(addr) + k / 8) % DEPTH), req, int'(got),
              int'(memByte((int'(addr) + k / 8) % DEPTH)));
        bytesDone++;
      end
      spiSclk = 1'b1;
      repeat (HP) @(negedge clk);
      spiSclk = 1'b0;
    end
    spiCsN = 1'b1;
    repeat (3) @(negedge clk);
    chk(spiMisoOe == 1'b0, "R5/R8 oe off after cs", int'(spiMisoOe), 0);
    if (!expectOut)
      chk(rdCount == startRd, "R6/R7 no read", rdCount - startRd, 0);
    else if (cutBit < 0)
      chk(rdCount - startRd == bytesDone + 1, "R9 read count", rdCount - startRd, bytesDone + 1);
    repeat (HP) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R8: reset state
    chk(spiMisoOe == 1'b0, "R8 oe in reset", int'(spiMisoOe), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(spiMisoOe == 1'b0, "R8 oe after reset", int'(spiMisoOe), 0);
    chk(memRdEn == 1'b0, "R9 idle read", int'(memRdEn), 0);

    // R1 R3 R4: every start address, three bytes, upper address bits varied
    for (int a = 0; a < DEPTH; a++)
      runCmd(8'h03, {6'(a), 12'h5A3, 6'(a)}, 3, -1, 1'b1, "R1/R3 data");

    // R4: long stream passing the top twice
    runCmd(8'h03, 24'h00003C, 2 * DEPTH + 6, -1, 1'b1, "R4 wrap data");

    // R5: abort mid-byte, then a fresh command decodes correctly
    runCmd(8'h03, 24'h000010, 4, 11, 1'b1, "R5 aborted data");
    runCmd(8'h03, 24'h000021, 2, -1, 1'b1, "R5 data after abort");
    runCmd(8'h03, 24'h000007, 2, 3, 1'b1, "R5 aborted data");
    runCmd(8'h03, 24'h00002E, 1, -1, 1'b1, "R5 data after abort");

    // R6: busy at opcode end rejects the command
    busy = 1'b1;
    runCmd(8'h03, 24'h000005, 2, -1, 1'b0, "R6 oe stays low");
    busy = 1'b0;
    runCmd(8'h03, 24'h000005, 2, -1, 1'b1, "R6 read after busy clears");

    // R7: other opcodes are ignored
    runCmd(8'h0B, 24'h000001, 1, -1, 1'b0, "R7 oe stays low");
    runCmd(8'h02, 24'h000001, 1, -1, 1'b0, "R7 oe stays low");
    runCmd(8'h83, 24'h000001, 1, -1, 1'b0, "R7 oe stays low");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule